// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by a fixed priority in which line 0 is most urgent, and signals a processor through a single interrupt output. When the processor acknowledges, the block returns an 8-bit vector, which is a programmable base plus the number of the winning line. It also records that line as being in service, so lines of equal or lower rank stay blocked until software ends the service.

Software reaches the block through a byte-wide port with one select bit: select 0 is the command port and select 1 is the data port. A command write with bit 4 set starts a setup sequence. The data writes that follow supply the vector base, an optional cascade-wiring byte and an optional mode byte. After setup, data writes load the mask. Command writes choose which register a command read returns, and they can end service on a named level. When the mode byte asks for automatic end of service, no in-service bit is kept. An acknowledge that finds no request eligible returns the line-7 vector and changes nothing.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the block is unconfigured. int_out and vec_valid are 0, a command read returns 0 and a data read returns 0xFF. Request edges are ignored until setup completes.
- R2: A command write with bit 4 set (for example 0x11) starts setup. It clears the mask, request and in-service registers, selects the request register for command reads, and makes the next data write the vector base.
- R3: In the setup byte, bit 1 = 1 means no cascade byte follows and bit 0 = 1 means a mode byte follows. With 0x12, only the base write is taken and the next data write loads the mask. With 0x11, the base, cascade and mode bytes are all consumed before mask writes resume.
- R4: After setup, a data write loads the mask (1 = line blocked). A data read returns the mask.
- R5: A rising edge on a request line sets its request bit, whether or not the line is masked. A line held high does not set the bit again after it has been cleared.
- R6: int_out is 1 only when an unmasked request exists whose line number is below every in-service line number.
- R7: An acknowledge pulse with int_out high gives vec_valid for one cycle on the following cycle, with vec_out = base + winning line. It clears that request bit and sets that in-service bit.
- R8: Command write 0x0B selects the in-service register for later command reads. Command write 0x0A selects the request register.
- R9: Command write 0x60+n clears in-service bit n only.
- R10: With mode byte bit 1 set (automatic end of service), an acknowledged line leaves no in-service bit set.
- R11: An acknowledge with int_out low returns base + 7 and leaves the in-service and request registers unchanged, even when line 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt to processor |
| ack | input | 1 | Acknowledge pulse |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | vec_out valid strobe |

## Verification
The hardest state to reach is a nested one. One line is already in service, a lower-ranked request is pending and blocked, and a higher-ranked request then preempts it. End-of-service commands must then unwind the levels in the right order. The stimulus gets there with directed edge sequences: it services line 3, raises line 5 and then line 1, and issues specific ends one at a time, reading the in-service register after each step. A second path leads to a spurious acknowledge: requests are pending but all masked, and the acknowledge is issued with the output low.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NIN = 8;
  localparam int IW  = $clog2(NIN);
  localparam int DW  = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_BASE, ST_CASC, ST_MODE, ST_RUN} init_st_e;

  // returns {found, index} of lowest set bit (highest priority)
  function automatic logic [IW:0] pick_lowest(input logic [NIN-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = NIN - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] vec_of(input logic [DW-1:0] base, input logic [IW-1:0] idx);
    return base + DW'(idx);
  endfunction
endpackage

// File: rtl/pic8_req_latch.sv
module pic8_req_latch #(
  parameter int N = pic8_pkg::NIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] lines,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lines;
  end

  assign rise = lines & ~prev & {N{en}};
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
  import pic8_pkg::*;
(
  input  logic [NIN-1:0] irr,
  input  logic [NIN-1:0] imr,
  input  logic [NIN-1:0] isr,
  output logic           win,
  output logic [IW-1:0]  win_idx
);
  logic [IW:0] req_pick, srv_pick;

  assign req_pick = pick_lowest(irr & ~imr);
  assign srv_pick = pick_lowest(isr);
  assign win_idx  = req_pick[IW-1:0];
  assign win      = req_pick[IW] && (!srv_pick[IW] || (req_pick[IW-1:0] < srv_pick[IW-1:0]));
endmodule

// File: rtl/pic8_init_seq.sv
module pic8_init_seq
  import pic8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic          ready,
  output logic          start_evt,
  output logic          mask_wr,
  output logic [DW-1:0] base,
  output logic [DW-1:0] casc,
  output logic          aeoi
);
  init_st_e st, st_nx;
  logic     want_mode, single;
  logic     data_wr;
  logic [DW-1:0] mode;

  assign start_evt = bus_wr && !bus_sel && bus_wdata[4];
  assign data_wr   = bus_wr && bus_sel;
  assign ready     = (st == ST_RUN);
  assign mask_wr   = data_wr && ready;
  assign aeoi      = mode[1];

  always_comb begin
    st_nx = st;
    if (start_evt) st_nx = ST_BASE;
    else if (data_wr) begin
      unique case (st)
        ST_BASE: st_nx = !single ? ST_CASC : (want_mode ? ST_MODE : ST_RUN);
        ST_CASC: st_nx = want_mode ? ST_MODE : ST_RUN;
        ST_MODE: st_nx = ST_RUN;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; want_mode <= 1'b0; single <= 1'b0;
      base <= '0; casc <= '0; mode <= '0;
    end else begin
      st <= st_nx;
      if (start_evt) begin
        want_mode <= bus_wdata[0];
        single    <= bus_wdata[1];
        mode      <= '0;
      end else if (data_wr) begin
        if (st == ST_BASE) base <= bus_wdata;
        if (st == ST_CASC) casc <= bus_wdata;
        if (st == ST_MODE) mode <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NIN-1:0] irq_in,
  output logic          int_out,
  input  logic          ack,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid
);
  logic          ready, start_evt, mask_wr, aeoi;
  logic [DW-1:0] base, casc;
  logic [NIN-1:0] irr, isr, imr, rise, irr_nx, isr_nx;
  logic          win;
  logic [IW-1:0] win_idx;
  logic          rd_isr;
  logic          cmd_wr, ack_evt, ack_real, ack_spur, seoi_evt, rsel_evt;
  logic [IW-1:0] seoi_lvl;

  pic8_init_seq u_init (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .ready(ready), .start_evt(start_evt), .mask_wr(mask_wr),
    .base(base), .casc(casc), .aeoi(aeoi)
  );

  pic8_req_latch #(.N(NIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(ready), .lines(irq_in), .rise(rise)
  );

  pic8_prio u_prio (
    .irr(irr), .imr(imr), .isr(isr), .win(win), .win_idx(win_idx)
  );

  assign cmd_wr   = bus_wr && !bus_sel && !bus_wdata[4] && ready;
  assign seoi_evt = cmd_wr && (bus_wdata[7:3] == 5'b01100);
  assign seoi_lvl = bus_wdata[IW-1:0];
  assign rsel_evt = cmd_wr && (bus_wdata[4:3] == 2'b01) && bus_wdata[1];
  assign ack_evt  = ack && ready;
  assign ack_real = ack_evt && win;
  assign ack_spur = ack_evt && !win;
  assign int_out  = ready && win;

  always_comb begin
    irr_nx = irr;
    isr_nx = isr;
    if (ack_real) begin
      irr_nx[win_idx] = 1'b0;
      if (!aeoi) isr_nx[win_idx] = 1'b1;
    end
    if (seoi_evt) isr_nx[seoi_lvl] = 1'b0;
    irr_nx = irr_nx | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '1; rd_isr <= 1'b0;
      vec_out <= '0; vec_valid <= 1'b0;
    end else begin
      vec_valid <= ack_evt;
      if (ack_evt) vec_out <= vec_of(base, ack_real ? win_idx : IW'(NIN - 1));
      if (start_evt) begin
        irr <= '0; isr <= '0; imr <= '0; rd_isr <= 1'b0;
      end else begin
        irr <= irr_nx;
        isr <= isr_nx;
        if (mask_wr)  imr <= bus_wdata;
        if (rsel_evt) rd_isr <= bus_wdata[0];
      end
    end
  end

  assign bus_rdata = bus_sel ? imr : (rd_isr ? isr : irr);

  logic unused_casc;
  assign unused_casc = ^casc;
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk
  import pic8_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           int_out,
  input logic           ack,
  input logic           bus_wr,
  input logic           vec_valid,
  input logic [NIN-1:0] irr,
  input logic [NIN-1:0] imr,
  input logic [NIN-1:0] isr,
  input logic           start_evt,
  input logic           seoi_evt,
  input logic [IW-1:0]  seoi_lvl,
  input logic           ack_real,
  input logic           ack_spur,
  input logic           aeoi
);
  AST_INT_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) int_out |-> ready); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> (irr == '0 && isr == '0 && imr == '0)); // R2
  AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) int_out |-> ((irr & ~imr) != '0)); // R6
  AST_ACK_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (ack && ready) |=> vec_valid); // R7
  AST_ACK_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n) (ack_real && !aeoi && !bus_wr) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R7
  AST_SEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (seoi_evt && !ack_real) |=> !isr[$past(seoi_lvl)]); // R9
  AST_AEOI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (ack_real && aeoi && !bus_wr) |=> $stable(isr)); // R10
  AST_SPUR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (ack_spur && !bus_wr) |=> $stable(isr)); // R11
endmodule

bind pic8_ctrl pic8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .int_out(int_out), .ack(ack), .bus_wr(bus_wr),
  .vec_valid(vec_valid), .irr(irr), .imr(imr), .isr(isr), .start_evt(start_evt),
  .seoi_evt(seoi_evt), .seoi_lvl(seoi_lvl), .ack_real(ack_real), .ack_spur(ack_spur), .aeoi(aeoi)
);

// File: tb/tb_pic8_ctrl.sv
module tb_pic8_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  // {mask, request lines, expected int_out, expected vector} with base 0x30
  localparam logic [24:0] TABLE [NT] = '{
    {8'h00, 8'h01, 1'b1, 8'h30},
    {8'h00, 8'h84, 1'b1, 8'h32},
    {8'h04, 8'h84, 1'b1, 8'h37},
    {8'hFF, 8'h80, 1'b0, 8'h37},
    {8'h0F, 8'h30, 1'b1, 8'h34},
    {8'h00, 8'hC0, 1'b1, 8'h36}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_sel = 0, ack = 0;
  logic [7:0] bus_wdata = 0, irq_in = 0;
  logic [7:0] bus_rdata, vec_out;
  logic int_out, vec_valid;
  int checks = 0, failures = 0;
  logic [7:0] got;

  pic8_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    bus_sel = sel; #1; d = bus_rdata;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    checks++;
    if (!vec_valid) begin failures++; $display("FAIL R7 vec_valid actual=0 expected=1"); end
    v = vec_out;
  endtask

  task automatic setup_full(input logic [7:0] b, input logic [7:0] m);
    wr(0, 8'h11); wr(1, b); wr(1, 8'h04); wr(1, m);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
    rd(0, got); chk("R1 cmd read", got, 8'h00);
    rd(1, got); chk("R1 data read", got, 8'hFF);
    lines(8'h01);
    rd(0, got); chk("R1 edge ignored before setup", got, 8'h00);
    chk("R1 int ignored", {7'b0, int_out}, 8'h00);
    lines(8'h00);

    // R3 single mode: only the base byte
    wr(0, 8'h12);
    rd(1, got); chk("R2 mask cleared", got, 8'h00);
    wr(1, 8'h40); wr(1, 8'h5A);
    rd(1, got); chk("R3 mask after single setup", got, 8'h5A);
    lines(8'h02);
    rd(0, got); chk("R5 masked edge latched", got, 8'h02);
    chk("R6 masked no int", {7'b0, int_out}, 8'h00);
    wr(1, 8'h00);
    chk("R4 unmask raises int", {7'b0, int_out}, 8'h01);
    do_ack(got); chk("R7 vector", got, 8'h41);
    rd(0, got); chk("R7 request cleared", got, 8'h00);
    wr(0, 8'h0B);
    rd(0, got); chk("R8 isr read", got, 8'h02);
    lines(8'h00);

    // R2 start clears and resets read select; R3 full sequence
    setup_full(8'h30, 8'h01);
    wr(1, 8'hA5);
    rd(1, got); chk("R3 mask after full setup", got, 8'hA5);
    wr(1, 8'h00);
    lines(8'h08);
    rd(0, got); chk("R2 read select back to request", got, 8'h08);
    lines(8'h00);

    // table of patterns
    for (int i = 0; i < NT; i++) begin
      setup_full(8'h30, 8'h01);
      wr(1, TABLE[i][24:17]);
      lines(TABLE[i][16:9]);
      chk($sformatf("R6 table %0d int", i), {7'b0, int_out}, {7'b0, TABLE[i][8]});
      do_ack(got);
      chk($sformatf("R7 R11 table %0d vector", i), got, TABLE[i][7:0]);
      lines(8'h00);
    end

    // nesting, priority blocking, specific end
    setup_full(8'h30, 8'h01);
    wr(1, 8'h00);
    lines(8'h08);
    do_ack(got); chk("R7 nested first", got, 8'h33);
    wr(0, 8'h0B);
    rd(0, got); chk("R8 isr after first", got, 8'h08);
    lines(8'h20);
    chk("R6 lower blocked", {7'b0, int_out}, 8'h00);
    lines(8'h22);
    chk("R6 higher preempts", {7'b0, int_out}, 8'h01);
    do_ack(got); chk("R7 nested second", got, 8'h31);
    rd(0, got); chk("R7 isr two levels", got, 8'h0A);
    wr(0, 8'h63);
    rd(0, got); chk("R9 clears only level 3", got, 8'h02);
    chk("R6 still blocked by 1", {7'b0, int_out}, 8'h00);
    wr(0, 8'h61);
    rd(0, got); chk("R9 clears level 1", got, 8'h00);
    chk("R6 pending 5 now eligible", {7'b0, int_out}, 8'h01);

    // spurious with all masked
    wr(1, 8'hFF);
    chk("R11 masked no int", {7'b0, int_out}, 8'h00);
    do_ack(got); chk("R11 spurious vector", got, 8'h37);
    rd(0, got); chk("R11 isr unchanged", got, 8'h00);
    wr(0, 8'h0A);
    rd(0, got); chk("R11 request unchanged", got, 8'h20);
    lines(8'h00);

    // automatic end of service
    setup_full(8'h50, 8'h03);
    wr(1, 8'h00);
    lines(8'h04);
    do_ack(got); chk("R10 vector", got, 8'h52);
    wr(0, 8'h0B);
    rd(0, got); chk("R10 no isr bit", got, 8'h00);
    wr(0, 8'h0A);
    rd(0, got); chk("R5 held line not relatched", got, 8'h00);
    chk("R10 int low", {7'b0, int_out}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule